// File: doc/BRIEF.md
# Chained Double-Capture Test Clock Gater

This block turns the free-running functional clocks of several clock domains into gated scan test clocks for logic self-test. While the scan chains are loaded, every domain gets its functional clock through unchanged, and a single slow scan enable stays high. When the loader reports that shifting has finished, the shift clocks stop. After a programmable launch gap, scan enable drops. The domains then take turns, each receiving exactly two capture pulses one functional period apart. This pair gives a launch edge and a capture edge for at-speed delay faults, with no change to any clock frequency.

The handoff runs in a fixed order, from domain 0 up to the last domain. The second capture pulse of one domain starts the pair of the next domain. The start event crosses into the receiving clock domain through a toggle and a two-flop synchronizer. It then waits a programmable number of cycles of the receiving clock, so the delay between domains can be made larger than the clock skew or tuned to a cross-domain timing target. After the last domain's second pulse, that event is carried back to the controller on clock 0. A resume gap then runs, and scan enable returns high together with a one-cycle done pulse. Shifting then continues.

Usage note: the launch gap must cover the shift-stop synchronizer of the slowest domain, which is three of its cycles.

Top module: `dchain_capture_clkgen`

## Requirements
- R1: During and after reset, with start_i low, scan_en_o and capture_done_o are low and no gclk_o bit pulses.
- R2: start_i sampled high by clk_i[0] while idle makes scan_en_o high after that edge. A few cycles later, every gclk_o bit follows its functional clock.
- R3: shift_done_i sampled high by clk_i[0] while shifting stops the shift pulses. scan_en_o falls exactly launch_gap_i+1 clk_i[0] cycles after that edge.
- R4: The first capture pulse of domain 0 rises exactly dom_gap_i[0]+5 clk_i[0] periods after scan_en_o falls.
- R5: In each capture window, every domain gives exactly two capture pulses, on consecutive rising edges of its own clock (spacing one period).
- R6: Capture pairs follow domain index order 0,1,..,NUM_DOM-1. The first pulse of domain k>0 rises more than dom_gap_i[k]+4 and at most dom_gap_i[k]+5 of its own periods after the second pulse of domain k-1.
- R7: scan_en_o rises more than resume_gap_i+3 and at most resume_gap_i+4 clk_i[0] periods after the second pulse of the last domain. capture_done_o is high for that one clk_i[0] cycle only, and shift pulses resume.
- R8: scan_en_o rises only when capture_done_o is high or when start_i was high at the previous clk_i[0] edge.
- R9: start_i sampled low while shifting returns the block to idle: scan_en_o is low, no gclk_o pulses, and no window is started.
- R10: Zero values for dom_gap_i and resume_gap_i are valid and give the minimum delays of R4, R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | NUM_DOM | Free-running functional clock per domain; bit 0 also clocks the controller |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Run level, synchronous to clk_i[0] |
| shift_done_i | input | 1 | Shift-complete strobe, synchronous to clk_i[0] |
| launch_gap_i | input | GAP_W | Extra clk_i[0] cycles between shift stop and scan enable drop |
| resume_gap_i | input | GAP_W | Extra clk_i[0] cycles before scan enable returns high |
| dom_gap_i | input | NUM_DOM x GAP_W | Per-domain wait, in cycles of the receiving clock, before its capture pair |
| gclk_o | output | NUM_DOM | Gated test clock per domain |
| scan_en_o | output | 1 | Global scan enable, high in shift mode |
| capture_done_o | output | 1 | One clk_i[0] cycle pulse at the end of each capture window |

## Verification
A stuck or skipped handoff state leaves the next domain silent. The window then never ends, so capture_done_o never comes and scan_en_o stays low. An off-by-one in a wait counter or a missing synchronizer stage moves a pulse by one period of the receiving clock, and the bench measures that exactly against the scan enable edge or the previous domain's pulse within a single window. A gate enable held one cycle too long shows up as a third pulse as soon as that domain's pair is issued.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [2:0] {
    C_IDLE,
    C_SHIFT,
    C_LGAP,
    C_CAP,
    C_RGAP
  } ctrl_st_e;

  typedef enum logic [1:0] {
    D_IDLE,
    D_WAIT,
    D_P1,
    D_P2
  } dom_st_e;
endpackage

// File: rtl/dcc_bit_sync.sv
module dcc_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr <= '0;
    else         sr <= {sr[STAGES-2:0], d_i};
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
  import dcc_pkg::*;
#(
  parameter int GAP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             shift_done_i,
  input  logic [GAP_W-1:0] launch_gap_i,
  input  logic [GAP_W-1:0] resume_gap_i,
  input  logic             last_tgl_i,
  output logic             shift_req_o,
  output logic             cap_tgl_o,
  output logic             scan_en_o,
  output logic             capture_done_o
);
  ctrl_st_e         st;
  logic [GAP_W-1:0] cnt;
  logic             last_q, last_d;
  logic             last_evt;

  dcc_bit_sync #(.STAGES(2)) u_last_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (last_tgl_i),
    .q_o   (last_q)
  );

  assign last_evt = last_q ^ last_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st             <= C_IDLE;
      cnt            <= '0;
      last_d         <= 1'b0;
      cap_tgl_o      <= 1'b0;
      shift_req_o    <= 1'b0;
      capture_done_o <= 1'b0;
    end else begin
      last_d         <= last_q;
      capture_done_o <= 1'b0;
      unique case (st)
        C_IDLE: if (start_i) begin
          st          <= C_SHIFT;
          shift_req_o <= 1'b1;
        end
        C_SHIFT: begin
          if (!start_i) begin
            st          <= C_IDLE;
            shift_req_o <= 1'b0;
          end else if (shift_done_i) begin
            st          <= C_LGAP;
            shift_req_o <= 1'b0;
            cnt         <= launch_gap_i;
          end
        end
        C_LGAP: begin
          if (cnt == '0) begin
            cap_tgl_o <= ~cap_tgl_o;
            st        <= C_CAP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        C_CAP: if (last_evt) begin
          st  <= C_RGAP;
          cnt <= resume_gap_i;
        end
        C_RGAP: begin
          if (cnt == '0) begin
            st             <= C_SHIFT;
            shift_req_o    <= 1'b1;
            capture_done_o <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  // enable stays high through the launch gap so it settles before any capture
  assign scan_en_o = (st == C_SHIFT) || (st == C_LGAP);
endmodule

// File: rtl/dcc_dom_gate.sv
module dcc_dom_gate
  import dcc_pkg::*;
#(
  parameter int GAP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_req_i,
  input  logic             trig_tgl_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             gclk_o,
  output logic             done_tgl_o
);
  dom_st_e          ph;
  logic [GAP_W-1:0] cnt;
  logic             shift_q, trig_q, trig_d, trig_evt;
  logic             cap_en, gate_en, en_lat;

  dcc_bit_sync #(.STAGES(2)) u_shift_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (shift_req_i),
    .q_o   (shift_q)
  );

  dcc_bit_sync #(.STAGES(2)) u_trig_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trig_tgl_i),
    .q_o   (trig_q)
  );

  assign trig_evt = trig_q ^ trig_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph         <= D_IDLE;
      cnt        <= '0;
      trig_d     <= 1'b0;
      cap_en     <= 1'b0;
      done_tgl_o <= 1'b0;
    end else begin
      trig_d <= trig_q;
      unique case (ph)
        D_IDLE: if (trig_evt) begin
          ph  <= D_WAIT;
          cnt <= gap_i;
        end
        D_WAIT: begin
          if (cnt == '0) begin
            ph     <= D_P1;
            cap_en <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        D_P1: ph <= D_P2;
        D_P2: begin
          // second capture edge: close the gate and hand off
          ph         <= D_IDLE;
          cap_en     <= 1'b0;
          done_tgl_o <= ~done_tgl_o;
        end
        default: ph <= D_IDLE;
      endcase
    end
  end

  assign gate_en = shift_q | cap_en;

  // enable passes only while the clock is low: no runt pulses
  always_latch begin
    if (!rst_ni)     en_lat = 1'b0;
    else if (!clk_i) en_lat = gate_en;
  end

  assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/dchain_capture_clkgen.sv
module dchain_capture_clkgen #(
  parameter int NUM_DOM = 3,
  parameter int GAP_W   = 6
) (
  input  logic [NUM_DOM-1:0]            clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          shift_done_i,
  input  logic [GAP_W-1:0]              launch_gap_i,
  input  logic [GAP_W-1:0]              resume_gap_i,
  input  logic [NUM_DOM-1:0][GAP_W-1:0] dom_gap_i,
  output logic [NUM_DOM-1:0]            gclk_o,
  output logic                          scan_en_o,
  output logic                          capture_done_o
);
  localparam int NUM_TGL = NUM_DOM + 1;

  if (NUM_DOM < 2 || NUM_DOM > 8) begin : g_bad_cfg
    $error("NUM_DOM must lie in 2..8");
  end

  logic [NUM_TGL-1:0] tgl;
  logic               shift_req;

  dcc_ctrl #(.GAP_W(GAP_W)) u_ctrl (
    .clk_i         (clk_i[0]),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .shift_done_i  (shift_done_i),
    .launch_gap_i  (launch_gap_i),
    .resume_gap_i  (resume_gap_i),
    .last_tgl_i    (tgl[NUM_DOM]),
    .shift_req_o   (shift_req),
    .cap_tgl_o     (tgl[0]),
    .scan_en_o     (scan_en_o),
    .capture_done_o(capture_done_o)
  );

  for (genvar k = 0; k < NUM_DOM; k++) begin : g_dom
    dcc_dom_gate #(.GAP_W(GAP_W)) u_gate (
      .clk_i      (clk_i[k]),
      .rst_ni     (rst_ni),
      .shift_req_i(shift_req),
      .trig_tgl_i (tgl[k]),
      .gap_i      (dom_gap_i[k]),
      .gclk_o     (gclk_o[k]),
      .done_tgl_o (tgl[k+1])
    );
  end
endmodule

// File: rtl/dcc_chk.sv
module dcc_chk #(
  parameter int NUM_DOM = 3,
  parameter int GAP_W   = 6
) (
  input logic [NUM_DOM-1:0]            clk_i,
  input logic                          rst_ni,
  input logic                          start_i,
  input logic                          shift_done_i,
  input logic [GAP_W-1:0]              launch_gap_i,
  input logic [GAP_W-1:0]              resume_gap_i,
  input logic [NUM_DOM-1:0][GAP_W-1:0] dom_gap_i,
  input logic [NUM_DOM-1:0]            gclk_o,
  input logic                          scan_en_o,
  input logic                          capture_done_o
);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i[0]) disable iff (!rst_ni)
    capture_done_o |=> !capture_done_o);

  // R7
  done_resume_chk: assert property (@(posedge clk_i[0]) disable iff (!rst_ni)
    capture_done_o |-> (scan_en_o && !$past(scan_en_o)));

  // R8
  se_rise_chk: assert property (@(posedge clk_i[0]) disable iff (!rst_ni)
    $rose(scan_en_o) |-> (capture_done_o || $past(start_i)));

  for (genvar k = 0; k < NUM_DOM; k++) begin : g_pair
    logic [1:0] cap_cnt;

    always_ff @(posedge gclk_o[k] or negedge rst_ni or posedge scan_en_o) begin
      if (!rst_ni)              cap_cnt <= '0;
      else if (scan_en_o)       cap_cnt <= '0;
      else if (cap_cnt != 2'd3) cap_cnt <= cap_cnt + 1'b1;
    end

    // R5
    pair_limit_chk: assert property (@(posedge gclk_o[k]) disable iff (!rst_ni || scan_en_o)
      cap_cnt < 2'd2);
  end
endmodule

bind dchain_capture_clkgen dcc_chk #(.NUM_DOM(NUM_DOM), .GAP_W(GAP_W)) u_dcc_chk (.*);

// File: tb/tb_dchain_capture_clkgen.sv
`timescale 1ns/1ps
module tb_dchain_capture_clkgen;
  localparam int N  = 3;
  localparam int GW = 6;
  localparam real P0 = 20.0;

  logic clk0, clk1, clk2;
  logic rst_n, start, shift_done, scan_en, cap_done;
  logic [GW-1:0] lgap, rgap;
  logic [N-1:0][GW-1:0] dgap;
  logic [N-1:0] gclk;

  dchain_capture_clkgen #(.NUM_DOM(N), .GAP_W(GW)) dut (
    .clk_i({clk2, clk1, clk0}), .rst_ni(rst_n), .start_i(start),
    .shift_done_i(shift_done), .launch_gap_i(lgap), .resume_gap_i(rgap),
    .dom_gap_i(dgap), .gclk_o(gclk), .scan_en_o(scan_en),
    .capture_done_o(cap_done)
  );

  initial begin clk0 = 0; forever #10   clk0 = ~clk0; end
  initial begin clk1 = 0; #3; forever #6.5  clk1 = ~clk1; end
  initial begin clk2 = 0; #7; forever #14.5 clk2 = ~clk2; end

  int  checks = 0, errors = 0;
  real per [N] = '{20.0, 13.0, 29.0};
  int  cur_g [N];
  int  cur_r;
  int  exp_q [$];
  int  edge_cnt [N];
  real t1 [N], t2 [N];
  real fall_t;
  bit  win_act = 0;

  task automatic chk_int(string req, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_real(string req, real act, real exp, string what);
    checks++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      errors++;
      $display("FAIL %s %s: act %0.3f exp %0.3f", req, what, act, exp);
    end
  endtask

  task automatic chk_range(string req, real act, real lo, real hi, string what);
    checks++;
    if (act <= lo + 0.01 || act > hi + 0.01) begin
      errors++;
      $display("FAIL %s %s: act %0.3f exp (%0.3f,%0.3f]", req, what, act, lo, hi);
    end
  endtask

  task automatic chk_min(string req, int act, int lo, string what);
    checks++;
    if (act < lo) begin
      errors++;
      $display("FAIL %s %s: act %0d exp >= %0d", req, what, act, lo);
    end
  endtask

  // monitor: pops expected capture pulses and checks order and timing
  task automatic on_pulse(input int k);
    real t;
    int  item;
    t = $realtime;
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R5 extra capture pulse: act domain %0d exp none", k);
      return;
    end
    item = exp_q.pop_front();
    chk_int("R6", k, item / 2, "pair order");
    if (item % 2 == 0) begin
      if (k == 0) chk_real("R4", t - fall_t, (cur_g[0] + 5) * P0, "first pulse dom0");
      else chk_range("R6", t - t2[k-1], (cur_g[k] + 4) * per[k], (cur_g[k] + 5) * per[k],
                     "handoff delay");
      t1[k] = t;
    end else begin
      chk_real("R5", t - t1[k], per[k], "pair spacing");
      t2[k] = t;
    end
  endtask

  for (genvar k = 0; k < N; k++) begin : g_mon
    always @(posedge gclk[k]) begin
      edge_cnt[k]++;
      if (win_act && !scan_en) on_pulse(k);
    end
  end

  always @(negedge scan_en) fall_t = $realtime;

  always @(posedge scan_en)
    if (win_act)
      chk_range("R7", $realtime - t2[N-1], (cur_r + 3) * P0, (cur_r + 4) * P0, "resume delay");

  task automatic snap(output int s [N]);
    for (int k = 0; k < N; k++) s[k] = edge_cnt[k];
  endtask

  task automatic run_window(input int l, input int r, input int g0, input int g1, input int g2,
                            input string tag);
    real t_sd;
    int  s [N];
    lgap = GW'(l); rgap = GW'(r);
    dgap[0] = GW'(g0); dgap[1] = GW'(g1); dgap[2] = GW'(g2);
    cur_g[0] = g0; cur_g[1] = g1; cur_g[2] = g2; cur_r = r;
    repeat (5) @(negedge clk0);
    for (int k = 0; k < N; k++) begin
      exp_q.push_back(2 * k);
      exp_q.push_back(2 * k + 1);
    end
    win_act = 1;
    shift_done = 1;
    t_sd = $realtime;
    @(negedge clk0);
    shift_done = 0;
    @(posedge cap_done);
    @(negedge clk0);
    chk_real("R3", fall_t - (t_sd + 10.0), (l + 1) * P0, {tag, " scan_en fall"});
    chk_int("R5", exp_q.size(), 0, {tag, " pulses left"});
    chk_int("R7", cap_done, 1, {tag, " done high"});
    chk_int("R8", scan_en, 1, {tag, " scan_en with done"});
    @(negedge clk0);
    chk_int("R7", cap_done, 0, {tag, " done one cycle"});
    win_act = 0;
    exp_q.delete();
    repeat (4) @(negedge clk0);
    snap(s);
    repeat (20) @(negedge clk0);
    for (int k = 0; k < N; k++) chk_min("R7", edge_cnt[k] - s[k], 10, {tag, " shift resumes"});
  endtask

  initial begin
    int s [N];
    for (int k = 0; k < N; k++) edge_cnt[k] = 0;
    rst_n = 0; start = 0; shift_done = 0;
    lgap = '0; rgap = '0; dgap = '0;
    repeat (5) @(negedge clk0);
    chk_int("R1", scan_en, 0, "scan_en in reset");
    rst_n = 1;
    snap(s);
    repeat (10) @(negedge clk0);
    for (int k = 0; k < N; k++) chk_int("R1", edge_cnt[k] - s[k], 0, "idle pulses");
    chk_int("R1", scan_en, 0, "scan_en idle");
    chk_int("R1", cap_done, 0, "done idle");

    start = 1;
    @(negedge clk0);
    chk_int("R2", scan_en, 1, "scan_en after start");
    repeat (4) @(negedge clk0);
    snap(s);
    repeat (20) @(negedge clk0);
    for (int k = 0; k < N; k++) chk_min("R2", edge_cnt[k] - s[k], 10, "shift pulses");

    run_window(6, 2, 1, 0, 2, "winA");
    run_window(8, 5, 3, 4, 1, "winB");
    // R10: zero domain and resume gaps
    run_window(3, 0, 0, 0, 0, "winC_R10");

    // R9: abort while shifting
    start = 0;
    @(negedge clk0);
    chk_int("R9", scan_en, 0, "scan_en after abort");
    repeat (5) @(negedge clk0);
    snap(s);
    repeat (20) @(negedge clk0);
    for (int k = 0; k < N; k++) chk_int("R9", edge_cnt[k] - s[k], 0, "pulses after abort");
    chk_int("R9", scan_en, 0, "scan_en stays low");
    chk_int("R9", cap_done, 0, "no window");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk0);
    checks++; errors++;
    $display("FAIL watchdog: act timeout exp finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule